// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides a fast input clock by either P or P+1. The choice is made once per output period by a modulus-control input. A 2-bit select input sets P to 8, 16, 32 or 64. Downstream swallow and main counters use the output as their clock: one single-cycle pulse per prescaler period. Those counters drive the modulus-control input to build a total division of N = P*B + A.

Internally there is a synchronous counter that divides by 4 or 5, followed by one to four binary toggle stages. The core counts to 5 only in the last core period of an output period, and only when the latched modulus is high. That adds exactly one input cycle per period, whatever P is.

The select and modulus inputs are captured in the same cycle as the output pulse, so a change never alters a period that is already running. While reset is held, both latches follow their inputs, so the first period after reset uses the values present at release.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With `mod_hi` low, the distance between output pulses is 8, 16, 32 or 64 input cycles for `p_sel` = 00, 01, 10, 11 respectively.
- R2: With `mod_hi` high, the distance is the R1 value plus exactly one (9, 17, 33, 65).
- R3: `div_out` is high for exactly one input cycle per period.
- R4: `mod_hi` is captured only on the clock edge at which `div_out` rises. That captured value sets the length of the period that starts there, and a change at any other time has no effect on the running period.
- R5: `p_sel` is captured on the same edge as `mod_hi` and follows the same rule as R4.
- R6: The reset is synchronous and active low. While `rst_n` is low, `div_out` is 0. After release, the first pulse rises on the L-th rising edge with `rst_n` high, where L is the selected ratio.
- R7: During reset, the capture registers follow `p_sel` and `mod_hi`, so the first period after release uses the values present at the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_hi | input | 1 | Modulus control: 1 selects P+1, 0 selects P |
| p_sel | input | 2 | Ratio select: 00=8, 01=16, 10=32, 11=64 |
| div_out | output | 1 | Single-cycle pulse, one per prescaler period |

## Verification
The bench measures the period for all eight combinations of ratio and modulus. A design that swallowed the extra count in every core period would show 10, 20, 40 or 80 cycles instead of P+1. The bench also toggles `mod_hi` and `p_sel` in the middle of a period. A design that used the new value at once would give a period length mixed between the old and the new setting. The latency to the first pulse after reset is checked against the full ratio, which exposes an off-by-one in the reset state or a missing reset-time capture.

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int NSTG = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_hi,
  input  logic [1:0] p_sel,
  output logic       div_out
);
  logic [2:0]      core_q;
  logic [NSTG-1:0] stg_q, stg_en, stg_t;
  logic [1:0]      sel_lat;
  logic            mod_lat, term, swallow, core_last, wrap, pulse_q;

  assign term      = &(stg_q | ~stg_en);
  assign swallow   = mod_lat & term;
  assign core_last = swallow ? (core_q == 3'd4) : (core_q == 3'd3);
  assign wrap      = core_last & term;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    assign stg_en[i] = (i <= int'(sel_lat));
    if (i == 0) begin : g_first
      assign stg_t[i] = core_last;
    end else begin : g_next
      assign stg_t[i] = stg_t[i-1] & stg_q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)          stg_q[i] <= 1'b0;
      else if (!stg_en[i]) stg_q[i] <= 1'b0;
      else                 stg_q[i] <= stg_q[i] ^ stg_t[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_q  <= '0;
      pulse_q <= 1'b0;
      sel_lat <= p_sel;
      mod_lat <= mod_hi;
    end else begin
      core_q  <= core_last ? 3'd0 : core_q + 3'd1;
      pulse_q <= wrap;
      if (wrap) begin
        sel_lat <= p_sel;
        mod_lat <= mod_hi;
      end
    end
  end

  assign div_out = pulse_q;
endmodule

// File: rtl/dual_mod_prescaler_chk.sv
module dual_mod_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       div_out,
  input logic       wrap,
  input logic       mod_lat,
  input logic [1:0] sel_lat
);
  logic [6:0] cnt, len_q;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; len_q <= '0; armed <= 1'b0;
    end else if (div_out) begin
      cnt   <= 7'd1;
      len_q <= (7'd8 << sel_lat) + {6'd0, mod_lat};
      armed <= 1'b1;
    end else begin
      cnt <= cnt + 7'd1;
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out && armed) |-> (cnt == len_q));

  // R2
  period_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt <= 7'd65));

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R4
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mod_lat));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(sel_lat));

  // R6
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> !div_out);
endmodule

bind dual_mod_prescaler dual_mod_prescaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_out(div_out),
  .wrap(wrap), .mod_lat(mod_lat), .sel_lat(sel_lat)
);

// File: tb/sim_dual_mod_prescaler.sv
`timescale 1ns/1ps
module sim_dual_mod_prescaler;
  logic clk = 1'b0, rst_n = 1'b0, mod_hi = 1'b0, div_out;
  logic [1:0] p_sel = 2'b00;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_mod_prescaler u0 (.clk(clk), .rst_n(rst_n), .mod_hi(mod_hi),
                         .p_sel(p_sel), .div_out(div_out));

  // {p_sel, mod_hi, expected length}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 1'b0, 7'd8},  {2'b00, 1'b1, 7'd9},
    {2'b01, 1'b0, 7'd16}, {2'b01, 1'b1, 7'd17},
    {2'b10, 1'b0, 7'd32}, {2'b10, 1'b1, 7'd33},
    {2'b11, 1'b0, 7'd64}, {2'b11, 1'b1, 7'd65}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_out && n < 200);
  endtask

  task automatic do_reset(input logic [1:0] s, input logic m);
    @(negedge clk);
    rst_n = 1'b0; p_sel = s; mod_hi = m;
    repeat (3) @(negedge clk);
    check("R6 reset", int'(div_out), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v][9:8], VEC[v][7]);
      measure(n);
      check("R6/R7 first", n, int'(VEC[v][6:0]));
      for (int k = 0; k < 3; k++) begin
        measure(n);
        check(VEC[v][7] ? "R2 period" : "R1 period", n, int'(VEC[v][6:0]));
      end
      @(negedge clk);
      check("R3 width", int'(div_out), 0);
      measure(n);
    end

    // R4: mid-period modulus changes
    do_reset(2'b00, 1'b0);
    measure(n);
    repeat (3) @(negedge clk);
    mod_hi = 1'b1;
    measure(n);
    check("R4 running", n, 5);
    measure(n);
    check("R4 next", n, 9);
    repeat (2) @(negedge clk);
    mod_hi = 1'b0;
    measure(n);
    check("R4 hold high", n, 7);
    measure(n);
    check("R4 back", n, 8);

    // R5: mid-period select changes
    repeat (4) @(negedge clk);
    p_sel = 2'b11;
    measure(n);
    check("R5 running", n, 4);
    measure(n);
    check("R5 next", n, 64);
    p_sel = 2'b01;
    measure(n);
    check("R5 hold", n, 64);
    measure(n);
    check("R5 new", n, 16);

    // R7: inputs changed right after release do not affect first period
    do_reset(2'b10, 1'b1);
    @(negedge clk);
    p_sel = 2'b00; mod_hi = 1'b0;
    measure(n);
    check("R7 first", n + 1, 33);
    measure(n);
    check("R1 after R7", n, 8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule